// File: doc/BRIEF.md
# SPI-Controlled Octal Output Latch

This block is a 16-bit serial slave that holds eight on/off channel enables. A fast system clock oversamples the serial clock, serial data and active-low chip select. Each pin passes through a two-flop synchronizer, and edges are detected in the system clock domain. Each transfer carries a control byte followed by a data byte. The data byte reaches the eight-channel output buffer only when the frame had exactly sixteen serial clock pulses and its control byte equals a fixed command code. During the same transfer, the block shifts a 16-bit diagnostic word, taken from an input vector, out on the serial data line, most significant bit first.

Channels 1 to 4 (`ch_on[3:0]`) can also be driven directly by parallel pulse-width inputs. A polarity input sets the active level of those inputs. Each of these four channels is on only when both its latched bit and its parallel input are active, so a latched 0 forces the channel off whatever the parallel input does. An asynchronous reset clears the buffer, which turns every channel off.

Top module: `octal_spi_latch`

## Requirements
- R1: While and after reset, `ch_on` is 8'h00, `spi_sdo_en` is 0, `spi_sdo` is 0 and `diag_clr` is 0.
- R2: A falling chip select captures `diag_word` into the transmit register. It also raises `spi_sdo_en` and presents `diag_word[15]` on `spi_sdo`.
- R3: Every rising serial clock after the first falling serial clock of a frame moves `spi_sdo` to the next lower diagnostic bit. A master that samples on each falling edge therefore reads the captured word MSB first.
- R4: `spi_sdi` is sampled on each falling serial clock, MSB first. The first 8 bits form the control byte and the last 8 bits form the data byte. The pulse counter saturates at 17.
- R5: On a rising chip select after exactly 16 pulses whose control byte is 8'hA5, the data byte is written to the buffer. Buffer bit i = 1 turns `ch_on[i]` (channel i+1) on, and 0 turns it off.
- R6: A frame with any pulse count other than 16 (for example 15 or 17) leaves the buffer unchanged and produces no `diag_clr`.
- R7: A 16-pulse frame whose control byte is not 8'hA5 leaves the buffer unchanged but still produces `diag_clr`.
- R8: `diag_clr` is high for exactly one system clock after each 16-pulse frame ends.
- R9: While chip select is high, serial clock and data activity has no effect, `spi_sdo_en` is 0 and `spi_sdo` is 0.
- R10: For i in 0..3, `ch_on[i]` = buffer bit i AND (`pwm_in[i]` == `pwm_hi_act`). With `pwm_hi_act` = 1 the parallel inputs are active-high, and with 0 they are active-low.
- R11: `ch_on[7:4]` follow the buffer alone and ignore `pwm_in`.
- R12: Asserting reset in the middle of operation clears the buffer immediately, so every channel turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdo | output | 1 | Serial diagnostic data; 0 when not enabled |
| spi_sdo_en | output | 1 | Output enable for an external tri-state driver on the data-out line |
| pwm_hi_act | input | 1 | Parallel input polarity: 1 for active-high, 0 for active-low |
| pwm_in | input | 4 | Parallel controls for channels 1 to 4 |
| diag_word | input | 16 | Diagnostic status captured at frame start |
| diag_clr | output | 1 | One-cycle request to clear the diagnostic status |
| ch_on | output | 8 | Channel enables; bit i drives channel i+1 |

## Verification
The assertions assume that the serial clock is low whenever chip select changes. They also assume that every serial pin holds each level for several system clocks, longer than the three-flop path through synchronizer and edge detector, so that no two edges of one pin merge. The stimulus holds each serial clock half period for eight system cycles and leaves idle gaps of ten cycles around each select. It changes `spi_sdi` only while the serial clock is low and keeps `diag_word` steady through a frame. Parallel inputs and polarity change only between frames, and reset is asserted only while the serial pins are idle.

// File: rtl/spi_latch_pkg.sv
package spi_latch_pkg;

  // Synchronized serial pin bundle; bit order used by the sync vector
  typedef struct packed {
    logic csn;
    logic sclk;
    logic sdi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{csn: 1'b1, sclk: 1'b0, sdi: 1'b0};

  // Pulse counter step that stops at lim
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Parallel input asserted for the selected polarity
  function automatic logic pwm_active(logic pin, logic hi_act);
    return pin == hi_act;
  endfunction

  // Frame length acceptance
  function automatic logic len_ok(int unsigned cnt, int unsigned want);
    return cnt == want;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= IDLE;
      prv <= IDLE;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prv <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int FRAME_W = 16,
  parameter int NUM_CH = 8,
  parameter logic [FRAME_W-NUM_CH-1:0] CMD_CODE = 8'hA5,
  localparam int CTRL_W = FRAME_W - NUM_CH,
  localparam int CNT_MAX = FRAME_W + 1,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_low,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi_lvl,
  input  logic [FRAME_W-1:0] diag_word,
  output logic               sdo,
  output logic               sdo_en,
  output logic               load_en,
  output logic [NUM_CH-1:0]  load_byte,
  output logic               diag_clr,
  output logic [CNT_W-1:0]   bit_cnt
);

  logic [FRAME_W-1:0] rx_q;
  logic [FRAME_W-1:0] tx_q;
  logic               act_q;
  logic               frame_len_ok;
  logic [CTRL_W-1:0]  ctrl_byte;

  assign ctrl_byte    = rx_q[FRAME_W-1 -: CTRL_W];
  assign load_byte    = rx_q[NUM_CH-1:0];
  assign frame_len_ok = spi_latch_pkg::len_ok(32'(bit_cnt), FRAME_W);
  assign load_en      = cs_rise && act_q && frame_len_ok && (ctrl_byte == CMD_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      tx_q     <= '0;
      act_q    <= 1'b0;
      bit_cnt  <= '0;
      diag_clr <= 1'b0;
    end else begin
      diag_clr <= cs_rise && act_q && frame_len_ok;
      if (cs_fall) begin
        act_q   <= 1'b1;
        tx_q    <= diag_word;
        bit_cnt <= '0;
      end else if (cs_rise) begin
        act_q <= 1'b0;
      end else if (act_q && cs_low) begin
        if (sck_fall) begin
          rx_q    <= {rx_q[FRAME_W-2:0], sdi_lvl};
          bit_cnt <= CNT_W'(spi_latch_pkg::sat_inc(32'(bit_cnt), CNT_MAX));
        end
        if (sck_rise && bit_cnt != '0) begin
          tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_en = act_q;
  assign sdo    = act_q & tx_q[FRAME_W-1];

endmodule

// File: rtl/chan_out_stage.sv
module chan_out_stage #(
  parameter int NUM_CH = 8,
  parameter int PWM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [NUM_CH-1:0] load_byte,
  input  logic [PWM_CH-1:0] pwm_in,
  input  logic              pwm_hi_act,
  output logic [NUM_CH-1:0] latch_q,
  output logic [NUM_CH-1:0] ch_on
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (load_en) latch_q <= load_byte;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i < PWM_CH) begin : g_par
      assign ch_on[i] = latch_q[i] & spi_latch_pkg::pwm_active(pwm_in[i], pwm_hi_act);
    end else begin : g_ser
      assign ch_on[i] = latch_q[i];
    end
  end

endmodule

// File: rtl/octal_spi_latch.sv
module octal_spi_latch #(
  parameter int NUM_CH = 8,
  parameter int PWM_CH = 4,
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [FRAME_W-NUM_CH-1:0] CMD_CODE = 8'hA5,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_sdi,
  input  logic               spi_csn,
  output logic               spi_sdo,
  output logic               spi_sdo_en,
  input  logic               pwm_hi_act,
  input  logic [PWM_CH-1:0]  pwm_in,
  input  logic [FRAME_W-1:0] diag_word,
  output logic               diag_clr,
  output logic [NUM_CH-1:0]  ch_on
);

  spi_latch_pkg::spi_pins_t pin_raw, pin_lvl, pin_prv;

  // Named events for the checker
  logic              cs_fall_ev, cs_rise_ev, sck_rise_ev, sck_fall_ev;
  logic              load_en;
  logic [NUM_CH-1:0] load_byte;
  logic [NUM_CH-1:0] out_buf;
  logic [CNT_W-1:0]  bit_cnt;
  logic              unused_sdi_prev;

  assign pin_raw = '{csn: spi_csn, sclk: spi_sclk, sdi: spi_sdi};

  spi_pin_sync #(
    .W($bits(spi_latch_pkg::spi_pins_t)),
    .STAGES(SYNC_STAGES),
    .IDLE(spi_latch_pkg::PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_raw), .lvl(pin_lvl), .prv(pin_prv)
  );

  assign cs_fall_ev      =  pin_prv.csn  & ~pin_lvl.csn;
  assign cs_rise_ev      = ~pin_prv.csn  &  pin_lvl.csn;
  assign sck_fall_ev     =  pin_prv.sclk & ~pin_lvl.sclk;
  assign sck_rise_ev     = ~pin_prv.sclk &  pin_lvl.sclk;
  assign unused_sdi_prev =  pin_prv.sdi;

  spi_frame_engine #(
    .FRAME_W(FRAME_W), .NUM_CH(NUM_CH), .CMD_CODE(CMD_CODE)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_low(~pin_lvl.csn), .cs_fall(cs_fall_ev), .cs_rise(cs_rise_ev),
    .sck_rise(sck_rise_ev), .sck_fall(sck_fall_ev), .sdi_lvl(pin_lvl.sdi),
    .diag_word(diag_word),
    .sdo(spi_sdo), .sdo_en(spi_sdo_en),
    .load_en(load_en), .load_byte(load_byte),
    .diag_clr(diag_clr), .bit_cnt(bit_cnt)
  );

  chan_out_stage #(
    .NUM_CH(NUM_CH), .PWM_CH(PWM_CH)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_byte(load_byte),
    .pwm_in(pwm_in), .pwm_hi_act(pwm_hi_act),
    .latch_q(out_buf), .ch_on(ch_on)
  );

endmodule

// File: rtl/octal_spi_latch_chk.sv
module octal_spi_latch_chk #(
  parameter int NUM_CH = 8,
  parameter int FRAME_W = 16,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall_ev,
  input logic              cs_rise_ev,
  input logic              load_en,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [NUM_CH-1:0] out_buf,
  input logic [NUM_CH-1:0] ch_on,
  input logic              diag_clr,
  input logic              spi_sdo,
  input logic              spi_sdo_en
);

  a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |=> !diag_clr);

  a_r6_clr_needs_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_ev && bit_cnt != CNT_W'(FRAME_W)) |=> !diag_clr);

  a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(out_buf));

  a_r2_en_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_ev |=> spi_sdo_en);

  a_r9_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sdo_en |-> !spi_sdo);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W + 1));

  a_r10_bit_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on & ~out_buf) == '0);

endmodule

bind octal_spi_latch octal_spi_latch_chk #(
  .NUM_CH(NUM_CH), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev),
  .load_en(load_en), .bit_cnt(bit_cnt), .out_buf(out_buf),
  .ch_on(ch_on), .diag_clr(diag_clr),
  .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en)
);

// File: tb/octal_spi_latch_test.sv
`timescale 1ns/1ps
module octal_spi_latch_test;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic        hi_act = 1'b1;
  logic [3:0]  pwm = 4'hF;
  logic [15:0] diag = 16'h0000;
  logic        sdo, sdo_en, dclr;
  logic [7:0]  ch_on;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  octal_spi_latch uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sdi(sdi), .spi_csn(csn),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .pwm_hi_act(hi_act), .pwm_in(pwm),
    .diag_word(diag), .diag_clr(dclr), .ch_on(ch_on)
  );

  // Behavioural reference: pin history queue, frame state in plain variables
  typedef struct { bit cs; bit sck; bit d; } pin_s;
  pin_s        hist[$];
  bit          m_act;
  bit [15:0]   m_tx, m_rx;
  int          m_cnt;
  bit [7:0]    m_buf;
  bit          m_clr;
  int          clr_seen = 0;

  function automatic pin_s idle_pins();
    pin_s p; p.cs = 1; p.sck = 0; p.d = 0; return p;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    pin_s cur, a, b;
    bit [7:0] exp_ch;
    if (!rst_n) begin
      hist = {idle_pins(), idle_pins(), idle_pins()};
      m_act = 0; m_tx = 0; m_rx = 0; m_cnt = 0; m_buf = 0; m_clr = 0;
    end else begin
      cur.cs = csn; cur.sck = sclk; cur.d = sdi;
      hist.push_back(cur);
      while (hist.size() > 4) void'(hist.pop_front());
      a = hist[0]; b = hist[1];
      m_clr = 0;
      if (a.cs && !b.cs) begin
        m_act = 1; m_tx = diag; m_cnt = 0;
      end else if (!a.cs && b.cs) begin
        if (m_act && m_cnt == 16) begin
          m_clr = 1;
          if (m_rx[15:8] == 8'hA5) m_buf = m_rx[7:0];
        end
        m_act = 0;
      end else if (m_act && !b.cs) begin
        if (a.sck && !b.sck) begin
          m_rx = {m_rx[14:0], b.d};
          if (m_cnt < 17) m_cnt++;
        end
        if (!a.sck && b.sck && m_cnt != 0) m_tx = m_tx << 1;
      end
    end
    exp_ch = m_buf;
    for (int i = 0; i < 4; i++) exp_ch[i] = m_buf[i] & (pwm[i] == hi_act);
    check("R5/R10/R11 ch_on", {8'h0, ch_on}, {8'h0, exp_ch});
    check("R2/R9 spi_sdo_en", {15'h0, sdo_en}, {15'h0, m_act});
    check("R3 spi_sdo", {15'h0, sdo}, {15'h0, m_act & m_tx[15]});
    check("R8 diag_clr", {15'h0, dclr}, {15'h0, m_clr});
    if (dclr) clr_seen++;
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      model_step();
    end
  endtask

  // One select period with nclk serial pulses; returns the word read on sdo
  task automatic frame(input logic [15:0] word, input int nclk, output logic [15:0] rd);
    rd = '0;
    csn = 0; step(HALF);
    for (int k = 0; k < nclk; k++) begin
      sdi = (k < 16) ? word[15-k] : 1'b0;
      step(2);
      sclk = 1; step(HALF);
      rd = {rd[14:0], sdo};
      sclk = 0; step(HALF);
    end
    csn = 1; sdi = 0; step(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int c0;
    step(3);
    // R1: reset state
    check("R1 ch_on in reset", {8'h0, ch_on}, 16'h0);
    check("R1 sdo_en in reset", {15'h0, sdo_en}, 16'h0);
    rst_n = 1; step(5);
    check("R1 ch_on after reset", {8'h0, ch_on}, 16'h0);
    check("R1 diag_clr after reset", {15'h0, dclr}, 16'h0);

    // R2/R3/R5/R8: valid frame, readback of diag word
    diag = 16'hB3C5; c0 = clr_seen;
    frame(16'hA5C1, 16, rd);
    check("R3 readback MSB first", rd, 16'hB3C5);
    check("R5 R4 buffer loaded MSB first", {8'h0, ch_on}, 16'h00C1);
    check("R8 single clr pulse", 16'(clr_seen - c0), 16'd1);

    // R6: 15 and 17 pulses rejected, no clear
    c0 = clr_seen;
    frame(16'hA5FF, 15, rd);
    check("R6 15 pulses ignored", {8'h0, ch_on}, 16'h00C1);
    frame(16'hA5FF, 17, rd);
    check("R6 17 pulses ignored", {8'h0, ch_on}, 16'h00C1);
    check("R6 no clr on bad length", 16'(clr_seen - c0), 16'd0);

    // R7: wrong control byte, outputs kept, clear still issued
    c0 = clr_seen;
    frame(16'h5AFF, 16, rd);
    check("R7 wrong command ignored", {8'h0, ch_on}, 16'h00C1);
    check("R7 clr still issued", 16'(clr_seen - c0), 16'd1);

    // R9: serial activity with select high
    for (int k = 0; k < 16; k++) begin
      sdi = k[0]; step(2); sclk = 1; step(HALF);
      check("R9 sdo_en low while deselected", {15'h0, sdo_en}, 16'h0);
      sclk = 0; step(HALF);
    end
    sdi = 0; step(4);
    check("R9 outputs untouched", {8'h0, ch_on}, 16'h00C1);

    // R10/R11: parallel inputs with both polarities
    diag = 16'h0F0F;
    frame(16'hA5FF, 16, rd);
    check("R3 second readback", rd, 16'h0F0F);
    hi_act = 1; pwm = 4'b0101; step(2);
    check("R10 active-high", {8'h0, ch_on}, 16'h00F5);
    hi_act = 0; step(2);
    check("R10 active-low", {8'h0, ch_on}, 16'h00FA);
    hi_act = 1; pwm = 4'b0000; step(2);
    check("R11 upper channels ignore pwm", {8'h0, ch_on}, 16'h00F0);
    pwm = 4'hF; step(2);
    frame(16'hA50A, 16, rd);
    check("R5 zero bits switch off", {8'h0, ch_on}, 16'h000A);

    // R12: reset mid-operation
    frame(16'hA5FF, 16, rd);
    rst_n = 0; step(2);
    check("R12 reset clears channels", {8'h0, ch_on}, 16'h0);
    rst_n = 1; step(5);
    check("R12 stays clear after reset", {8'h0, ch_on}, 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule